// File: doc/BRIEF.md
# CSR Privilege Access Checker

This block sits in front of a control/status register file and rules on every software access to it. It takes the 12-bit register address, separate read and write strobes, the current privilege level and a debug-mode flag. It returns a grant to the register file. It also returns an exception flag with a cause code for any access that must be refused.

The minimum privilege for a register is decoded from its own address. Every address goes through the same privilege comparison, with no exemptions; the machine exception PC at 0x341 gets no special treatment. There are two further gates on top of the privilege test. One is a debug-only address window. The other is a read-only class that refuses writes.

The grant is combinational, so a refused access never reaches the register file in the cycle it is presented. The exception flag is registered and rises in the following cycle.

Top module: `csr_priv_gate`

## Requirements
- R1: While `rst_n` is low at a clock edge, `exc_valid_o` and `exc_cause_o` are 0 after that edge, even when a faulting access is presented.
- R2: The required level comes from address bits [9:8], encoded 00 user, 01 supervisor, 10 hypervisor, 11 machine. The current level uses the same code. An access faults unless (current AND required) equals required.
- R3: Address 0x341, the machine exception PC, faults for a read or a write from user, supervisor or hypervisor level. It is granted at machine level.
- R4: An address whose bits [11:4] equal 0x7B faults whenever `dbg_mode_i` is 0. This holds at machine level too. The address passes this gate when `dbg_mode_i` is 1.
- R5: An address whose bits [11:10] equal 2'b11 is read-only. A write to it faults at any level. A read at sufficient level is granted.
- R6: When neither strobe is high, `grant_o` is 0 and no exception is raised in the next cycle, whatever the address and level.
- R7: `grant_o` is high in the same cycle as a request exactly when that request does not fault. It is never high together with a fault.
- R8: `exc_valid_o` is high in the cycle after each faulting request, for one cycle per faulting cycle, with `exc_cause_o` equal to 2 (illegal instruction). Otherwise `exc_cause_o` is 0.
- R9: When both strobes are high, the access is judged as a write. This covers the read-only check as well as the other checks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_addr_i | input | 12 | Address of the register being accessed |
| rd_req_i | input | 1 | Read request strobe |
| wr_req_i | input | 1 | Write request strobe |
| cur_priv_i | input | 2 | Current privilege level (00 U, 01 S, 10 H, 11 M) |
| dbg_mode_i | input | 1 | High while the hart is in debug mode |
| grant_o | output | 1 | Access may proceed to the register file (same cycle) |
| exc_valid_o | output | 1 | Registered exception flag for the previous cycle's access |
| exc_cause_o | output | 4 | Exception cause: 2 when `exc_valid_o` is high, else 0 |

## Verification
A privilege shortfall can fall in the same cycle as a debug-window miss or a read-only write. For example, user level can write 0xF11 or 0x7B0 with debug mode off. The sweep covers every level against every address class, under both strobes and both debug states, so these overlapping cases are applied directly. They are judged by the same rule as single faults: one exception in the next cycle, with cause 2 and the grant low in the request cycle. Doubled or missing reports are counted as mismatches by the scoreboard.

// File: rtl/csr_gate_pkg.sv
// Shared types for the CSR privilege checker.
// Assumes a 2-bit privilege code in which the bits of a lower level are a
// subset of the bits of every level allowed to reach it.
package csr_gate_pkg;
    typedef enum logic [1:0] {
        PRIV_U = 2'b00,
        PRIV_S = 2'b01,
        PRIV_H = 2'b10,
        PRIV_M = 2'b11
    } priv_e;

    localparam int CAUSE_W = 4;
    localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL = 4'd2;

    typedef struct packed {
        priv_e need;     // minimum level encoded in the address
        logic  ro;       // register refuses writes
        logic  dbg_only; // register lives in the debug window
    } csr_class_t;
endpackage

// File: rtl/csr_addr_class.sv
// Decodes a CSR address into its access class: the level it requires,
// whether it is read-only and whether it is debug-only.
// Assumes ADDR_W >= DBG_TAG_W and ADDR_W >= 4.
module csr_addr_class
    import csr_gate_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DBG_TAG_W = 8,
    parameter logic [DBG_TAG_W-1:0] DBG_TAG = 8'h7B
) (
    input  logic [ADDR_W-1:0] addr_i,
    output csr_class_t        cls_o
);
    localparam int LVL_LSB = ADDR_W - 4;
    localparam int RO_LSB  = ADDR_W - 2;

    // Pure field extraction from the address.
    always_comb begin
        cls_o.need     = priv_e'(addr_i[LVL_LSB +: 2]);
        cls_o.ro       = &addr_i[RO_LSB +: 2];
        cls_o.dbg_only = (addr_i[ADDR_W-1 -: DBG_TAG_W] == DBG_TAG);
    end
endmodule

// File: rtl/csr_access_judge.sv
// Combines a decoded class with the hart state and the strobes.
// Produces a same-cycle grant and a fault indication.
// Assumes the strobes are already qualified by a valid instruction.
module csr_access_judge
    import csr_gate_pkg::*;
(
    input  csr_class_t  cls_i,
    input  logic [1:0]  cur_priv_i,
    input  logic        dbg_mode_i,
    input  logic        rd_req_i,
    input  logic        wr_req_i,
    output logic        grant_o,
    output logic        fault_o
);
    logic req;
    logic lvl_short;
    logic dbg_miss;
    logic ro_write;

    // Evaluate each rule independently, then merge; no address is exempt.
    always_comb begin
        req       = rd_req_i | wr_req_i;
        lvl_short = (cur_priv_i & cls_i.need) != cls_i.need;
        dbg_miss  = cls_i.dbg_only & ~dbg_mode_i;
        ro_write  = cls_i.ro & wr_req_i;
        fault_o   = req & (lvl_short | dbg_miss | ro_write);
        grant_o   = req & ~(lvl_short | dbg_miss | ro_write);
    end
endmodule

// File: rtl/csr_exc_hold.sv
// Registers the fault into a one-cycle exception flag with its cause code.
// Assumes a synchronous active-low reset.
module csr_exc_hold
    import csr_gate_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fault_i,
    output logic               valid_o,
    output logic [CAUSE_W-1:0] cause_o
);
    // Capture this cycle's fault for reporting in the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            cause_o <= '0;
        end else begin
            valid_o <= fault_i;
            cause_o <= fault_i ? CAUSE_ILLEGAL : '0;
        end
    end

    assert_cause_tag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> cause_o == CAUSE_ILLEGAL);
    assert_cause_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> cause_o == '0);
endmodule

// File: rtl/csr_priv_gate.sv
// CSR privilege access checker: grants or refuses each register access.
// A refused access raises an illegal-instruction exception one cycle later.
// Assumes the address, strobes, level and debug flag are stable within a cycle.
module csr_priv_gate
    import csr_gate_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  csr_addr_i,
    input  logic               rd_req_i,
    input  logic               wr_req_i,
    input  logic [1:0]         cur_priv_i,
    input  logic               dbg_mode_i,
    output logic               grant_o,
    output logic               exc_valid_o,
    output logic [CAUSE_W-1:0] exc_cause_o
);
    localparam logic [ADDR_W-1:0] MEPC_ADDR = ADDR_W'(12'h341);

    csr_class_t cls;
    logic       fault;

    csr_addr_class #(.ADDR_W(ADDR_W)) u_class (
        .addr_i (csr_addr_i),
        .cls_o  (cls)
    );

    csr_access_judge u_judge (
        .cls_i      (cls),
        .cur_priv_i (cur_priv_i),
        .dbg_mode_i (dbg_mode_i),
        .rd_req_i   (rd_req_i),
        .wr_req_i   (wr_req_i),
        .grant_o    (grant_o),
        .fault_o    (fault)
    );

    csr_exc_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .fault_i (fault),
        .valid_o (exc_valid_o),
        .cause_o (exc_cause_o)
    );

    assert_level_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_req_i || wr_req_i) &&
         ((cur_priv_i & csr_addr_i[ADDR_W-3 -: 2]) != csr_addr_i[ADDR_W-3 -: 2]))
        |=> exc_valid_o);
    assert_mepc_guard_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_req_i || wr_req_i) && csr_addr_i == MEPC_ADDR && cur_priv_i != 2'b11)
        |=> exc_valid_o);
    assert_dbg_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_req_i || wr_req_i) && csr_addr_i[ADDR_W-1 -: 8] == 8'h7B && !dbg_mode_i)
        |=> exc_valid_o);
    assert_ro_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_i && csr_addr_i[ADDR_W-1 -: 2] == 2'b11) |=> exc_valid_o);
    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_req_i && !wr_req_i) |-> (!grant_o ##1 !exc_valid_o));
    assert_grant_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |=> !exc_valid_o);
endmodule

// File: tb/csr_priv_gate_tb_top.sv
// Scoreboard bench: the driver applies accesses, checks the same-cycle grant
// and queues the expected exception; the monitor compares after each edge.
module csr_priv_gate_tb_top;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        bit    exc;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] csr_addr_i = '0;
    logic        rd_req_i = 1'b0;
    logic        wr_req_i = 1'b0;
    logic [1:0]  cur_priv_i = '0;
    logic        dbg_mode_i = 1'b0;
    logic        grant_o;
    logic        exc_valid_o;
    logic [3:0]  exc_cause_o;

    int   checks = 0;
    int   errors = 0;
    bit   running = 1'b0;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    csr_priv_gate dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .csr_addr_i  (csr_addr_i),
        .rd_req_i    (rd_req_i),
        .wr_req_i    (wr_req_i),
        .cur_priv_i  (cur_priv_i),
        .dbg_mode_i  (dbg_mode_i),
        .grant_o     (grant_o),
        .exc_valid_o (exc_valid_o),
        .exc_cause_o (exc_cause_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one access at the falling edge; check grant, queue expectation.
    task automatic apply(input logic [11:0] a, input bit rd, input bit wr,
                         input logic [1:0] p, input bit dbg);
        bit    req;
        bit    flt;
        string tag;
        @(negedge clk);
        csr_addr_i = a; rd_req_i = rd; wr_req_i = wr;
        cur_priv_i = p; dbg_mode_i = dbg;
        req = rd | wr;
        flt = req && (((p & a[9:8]) != a[9:8]) ||
                      (a[11:4] == 8'h7B && !dbg) ||
                      (wr && a[11:10] == 2'b11));
        if (!req)                                 tag = "R6";
        else if (a == 12'h341)                    tag = "R3";
        else if (a[11:4] == 8'h7B)                tag = "R4";
        else if (rd && wr)                        tag = "R9";
        else if (a[11:10] == 2'b11)               tag = "R5";
        else                                      tag = "R2";
        sb_q.push_back('{flt, tag});
        #1;
        check(grant_o == (req && !flt), {"R7 grant ", tag}, grant_o, req && !flt);
    endtask

    // Monitor: compare the registered exception just after each rising edge.
    always @(posedge clk) begin
        #2;
        if (running && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(exc_valid_o == e.exc, {e.tag, " exc_valid"}, exc_valid_o, e.exc);
            check(exc_cause_o == (e.exc ? 4'd2 : 4'd0), "R8 cause",
                  exc_cause_o, e.exc ? 2 : 0);
        end
    end

    initial begin
        logic [11:0] addrs [9];
        addrs = '{12'h001, 12'hC00, 12'h100, 12'h200, 12'h300,
                  12'h341, 12'hF11, 12'h7B0, 12'h7B2};
        // R1: reset holds the exception low even with a faulting access.
        repeat (3) @(negedge clk);
        csr_addr_i = 12'h341; rd_req_i = 1'b1; cur_priv_i = 2'b00;
        @(negedge clk);
        check(exc_valid_o == 1'b0, "R1 valid in reset", exc_valid_o, 0);
        check(exc_cause_o == 4'd0, "R1 cause in reset", exc_cause_o, 0);
        rd_req_i = 1'b0;
        rst_n = 1'b1;
        running = 1'b1;
        // Sweep: every level against every address class, both strobes, both debug states.
        for (int p = 0; p < 4; p++)
            for (int i = 0; i < 9; i++)
                for (int d = 0; d < 2; d++) begin
                    apply(addrs[i], 1'b1, 1'b0, 2'(p), d[0]);
                    apply(addrs[i], 1'b0, 1'b1, 2'(p), d[0]);
                    apply(addrs[i], 1'b1, 1'b1, 2'(p), d[0]);
                    apply(addrs[i], 1'b0, 1'b0, 2'(p), d[0]);
                end
        // Back-to-back faults then a granted access.
        apply(12'h341, 1'b1, 1'b0, 2'b00, 1'b0);
        apply(12'h341, 1'b0, 1'b1, 2'b01, 1'b0);
        apply(12'h341, 1'b0, 1'b1, 2'b11, 1'b0);
        apply(12'h000, 1'b0, 1'b0, 2'b00, 1'b0);
        repeat (3) @(negedge clk);
        running = 1'b0;
        if (sb_q.size() != 0) check(1'b0, "R8 scoreboard drain", sb_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 20000);
        check(1'b0, "watchdog R8", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule